// File: doc/BRIEF.md
# Prescaled Input Capture Glitch Filter

This block conditions one timer input-capture pin before it reaches the capture edge detector. The raw pin is first taken through a two-flop synchronizer in the system clock domain. It then passes through a four-stage delay line that moves only on the enable cycles of the timer input clock. A stability filter follows, which accepts a new level only after that level has stayed unchanged for a programmable number of filter ticks. The filter tick is a clock enable made from the system clock by a programmable divider. It does not come from the timer counter clock.

A 4-bit divider field `flt_psc` makes one filter tick every `flt_psc + 1` system clock cycles. A 4-bit length field `flt_val` sets the number of ticks to `1 + 4*flt_val`. If either field is zero the filter is bypassed and the delayed level is registered straight to the output. Each change of the filtered level raises a one-cycle `rise_pulse` or `fall_pulse`. The block has no data stream. All pins are plain control and status signals with no handshake.

Top module: `capture_glitch_filter`

## Requirements
- R1: While `rst_n` is low, `flt_level`, `rise_pulse` and `fall_pulse` are 0, even when `pin_raw` is 1.
- R2: When `flt_psc` is 0 or `flt_val` is 0, `flt_level` follows `pin_raw`. With `tmr_tick` held at 1, a change of `pin_raw` just after a clock edge shows on `flt_level` after exactly 7 rising clock edges: 2 synchronizer, 4 delay-line and 1 output.
- R3: The four delay-line stages move only on cycles where `tmr_tick` is 1. With `tmr_tick` held at 0, a pin change never reaches `flt_level`. With `tmr_tick` high one cycle in three, the bypass latency grows to between 11 and 16 cycles.
- R4: In filter mode a filter tick occurs once every `flt_psc + 1` system clock cycles, counted on the system clock and never on `tmr_tick`. Two ticks are never adjacent.
- R5: In filter mode a new level is accepted only on the filter tick at which it has been stable for `1 + 4*flt_val` ticks. Between ticks `flt_level` does not change. With `flt_psc`=1 and `flt_val`=1, a rise appears 12 to 20 cycles after the pin change.
- R6: A level that returns before the tick count is reached restarts the count from zero and causes no edge. Example: a 6-cycle pulse with `flt_psc`=1 and `flt_val`=1.
- R7: Each change of `flt_level` gives exactly one `rise_pulse` (0 to 1) or `fall_pulse` (1 to 0), one cycle wide. The two pulses are never high together.
- R8: Any change of `flt_psc` or `flt_val` restarts the divider and the stability count. With `flt_psc`=3, a change of `flt_val` from 2 to 3 part-way through a count gives no rise for at least 45 cycles after the change.
- R9: At the largest settings (`flt_psc`=15, `flt_val`=15: 61 ticks of 16 cycles), a 900-cycle pulse is rejected. A held level rises 950 to 1000 cycles after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous capture pin |
| flt_psc | input | 4 | Filter tick divider; tick every value+1 cycles, 0 bypasses |
| flt_val | input | 4 | Filter length; 1+4*value ticks, 0 bypasses |
| tmr_tick | input | 1 | Timer input clock enable that moves the delay line |
| flt_level | output | 1 | Filtered pin level |
| rise_pulse | output | 1 | One-cycle pulse on a 0 to 1 change of flt_level |
| fall_pulse | output | 1 | One-cycle pulse on a 1 to 0 change of flt_level |

## Verification
The checker watches every cycle for these properties:
- edge pulses stay quiet in reset and never overlap;
- pulses agree with the changes of `flt_level`;
- filter ticks are never adjacent;
- the filtered level stays unchanged in filter mode on any cycle without a tick.

Only the directed scenarios can show the numbers:
- the exact bypass latency;
- the effect of a slow or stopped `tmr_tick`;
- whether a pulse of a given width is rejected or accepted;
- the restart of the count after a configuration change.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  localparam int SYNC_FLOPS = 2;
  localparam int DELAY_TAPS = 4;
  localparam int DIV_W      = 4;
  localparam int LEN_W      = 4;
  localparam int CNT_W      = LEN_W + 2;
endpackage

// File: rtl/cgf_pin_sync.sv
module cgf_pin_sync #(
  parameter int SYNC_N = cgf_pkg::SYNC_FLOPS,
  parameter int TAP_N  = cgf_pkg::DELAY_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic adv_i,
  output logic lvl_o
);
  logic [SYNC_N-1:0] meta_q;
  logic [TAP_N-1:0]  tap_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_N; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    meta_q[gi] <= 1'b0;
        else if (gi == 0) meta_q[gi] <= pin_i;
        else           meta_q[gi] <= meta_q[(gi > 0) ? gi-1 : 0];
      end
    end
    for (gi = 0; gi < TAP_N; gi++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tap_q[gi] <= 1'b0;
        else if (adv_i) begin
          if (gi == 0)  tap_q[gi] <= meta_q[SYNC_N-1];
          else          tap_q[gi] <= tap_q[(gi > 0) ? gi-1 : 0];
        end
      end
    end
  endgenerate

  assign lvl_o = tap_q[TAP_N-1];
endmodule

// File: rtl/cgf_tick_gen.sv
module cgf_tick_gen #(
  parameter int DW = cgf_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_i,
  input  logic          restart_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart_i || div_i == '0) cnt_q <= '0;
    else if (at_end)                  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (div_i != '0) && !restart_i && at_end;
endmodule

// File: rtl/cgf_stab_filter.sv
module cgf_stab_filter #(
  parameter int LW = cgf_pkg::LEN_W,
  localparam int CW = LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  input  logic [LW-1:0] len_i,
  input  logic          bypass_i,
  input  logic          restart_i,
  input  logic          tick_i,
  output logic          lvl_o
);
  logic [CW-1:0] run_q;
  logic [CW-1:0] last_cnt;
  logic          lvl_q;

  assign last_cnt = {len_i, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (bypass_i) begin
      lvl_q <= lvl_i;
      run_q <= '0;
    end else if (restart_i || lvl_i == lvl_q) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (run_q == last_cnt) begin
        lvl_q <= lvl_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/cgf_edge_det.sv
module cgf_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i && !prev_q;
  assign fall_o = !lvl_i && prev_q;
endmodule

// File: rtl/capture_glitch_filter.sv
module capture_glitch_filter #(
  parameter int DIV_W  = cgf_pkg::DIV_W,
  parameter int LEN_W  = cgf_pkg::LEN_W,
  parameter int SYNC_N = cgf_pkg::SYNC_FLOPS,
  parameter int TAP_N  = cgf_pkg::DELAY_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic [DIV_W-1:0] flt_psc,
  input  logic [LEN_W-1:0] flt_val,
  input  logic             tmr_tick,
  output logic             flt_level,
  output logic             rise_pulse,
  output logic             fall_pulse
);
  localparam int CFG_W = DIV_W + LEN_W;

  logic             synced_lvl;
  logic             filt_tick;
  logic             cfg_restart;
  logic             filt_bypass;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {flt_psc, flt_val};
  end

  assign cfg_restart = ({flt_psc, flt_val} != cfg_q);
  assign filt_bypass = (flt_psc == '0) || (flt_val == '0);

  cgf_pin_sync #(.SYNC_N(SYNC_N), .TAP_N(TAP_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_raw), .adv_i(tmr_tick), .lvl_o(synced_lvl)
  );

  cgf_tick_gen #(.DW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(flt_psc), .restart_i(cfg_restart), .tick_o(filt_tick)
  );

  cgf_stab_filter #(.LW(LEN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl_i(synced_lvl), .len_i(flt_val),
    .bypass_i(filt_bypass), .restart_i(cfg_restart), .tick_i(filt_tick), .lvl_o(flt_level)
  );

  cgf_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(flt_level), .rise_o(rise_pulse), .fall_o(fall_pulse)
  );
endmodule

// File: rtl/cgf_checker.sv
module cgf_checker #(
  parameter int DIV_W = cgf_pkg::DIV_W,
  parameter int LEN_W = cgf_pkg::LEN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] psc,
  input logic [LEN_W-1:0] val,
  input logic             ftick,
  input logic             level,
  input logic             rise,
  input logic             fall
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!rise && !fall)); // R1
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) (ftick && psc != '0) |=> !ftick); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (psc != '0 && val != '0 && !ftick) |=> $stable(level)); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rise && fall)); // R7
  AST_ROSE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(level) |-> rise); // R7
  AST_FELL_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(level) |-> fall); // R7
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R7
endmodule

bind capture_glitch_filter cgf_checker #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_cgf_chk (
  .clk(clk), .rst_n(rst_n), .psc(flt_psc), .val(flt_val), .ftick(filt_tick),
  .level(flt_level), .rise(rise_pulse), .fall(fall_pulse)
);

// File: tb/capture_glitch_filter_bench.sv
module capture_glitch_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [3:0] flt_psc = 4'd0;
  logic [3:0] flt_val = 4'd0;
  logic       tmr_tick;
  logic       flt_level, rise_pulse, fall_pulse;

  int total = 0;
  int bad = 0;
  int tdiv = 1;
  int tcnt = 0;
  int rise_n = 0;
  int fall_n = 0;
  bit prev_rise = 0;

  capture_glitch_filter u_capture_glitch_filter (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .flt_psc(flt_psc), .flt_val(flt_val),
    .tmr_tick(tmr_tick), .flt_level(flt_level), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tmr_tick = (tdiv == 1) ? 1'b1 : (tdiv == 0) ? 1'b0 : (tcnt == 0);
  always @(posedge clk) tcnt <= (tdiv > 1) ? ((tcnt + 1) % tdiv) : 0;

  always @(negedge clk) begin
    if (rise_pulse) rise_n++;
    if (fall_pulse) fall_n++;
    if (rise_pulse && fall_pulse) begin
      total++; bad++;
      $display("FAIL R7: both pulses high act=11 exp=not both");
    end
    if (rise_pulse && prev_rise) begin
      total++; bad++;
      $display("FAIL R7: rise pulse wider than one cycle act=2 exp=1");
    end
    prev_rise = rise_pulse;
  end

  task automatic check(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp_v);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles from the current negedge until rise_pulse is seen, limit+1 if never.
  task automatic wait_rise(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (rise_pulse) begin n = i; break; end
    end
  endtask

  task automatic settle_low();
    pin_raw = 1'b0;
    flt_psc = 4'd0;
    flt_val = 4'd0;
    tdiv = 1;
    cycles(12);
  endtask

  task automatic t_reset();
    pin_raw = 1'b1;
    cycles(5);
    check("R1 level in reset", int'(flt_level), 0);
    check("R1 pulses in reset", rise_n + fall_n, 0);
    pin_raw = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(10);
    check("R1 level after reset", int'(flt_level), 0);
  endtask

  task automatic t_bypass(input logic [3:0] p, input logic [3:0] v);
    int r0, f0;
    settle_low();
    flt_psc = p; flt_val = v;
    cycles(3);
    r0 = rise_n; f0 = fall_n;
    pin_raw = 1'b1;
    cycles(6);
    check("R2 level before 7 edges", int'(flt_level), 0);
    @(negedge clk);
    check("R2 level at 7 edges", int'(flt_level), 1);
    check("R7 rise at 7 edges", int'(rise_pulse), 1);
    @(negedge clk);
    check("R7 rise one cycle", int'(rise_pulse), 0);
    pin_raw = 1'b0;
    cycles(7);
    check("R2 fall at 7 edges", int'(fall_pulse), 1);
    cycles(3);
    check("R7 one rise", rise_n - r0, 1);
    check("R7 one fall", fall_n - f0, 1);
  endtask

  task automatic t_timer_gate();
    int n;
    settle_low();
    tdiv = 0;
    pin_raw = 1'b1;
    cycles(40);
    check("R3 no advance without tmr_tick", int'(flt_level), 0);
    settle_low();
    tdiv = 3;
    cycles(6);
    pin_raw = 1'b1;
    wait_rise(40, n);
    check_range("R3 slow tmr_tick latency", n, 11, 16);
  endtask

  task automatic t_filter_basic();
    int n, r0;
    settle_low();
    flt_psc = 4'd1; flt_val = 4'd1;
    cycles(4);
    r0 = rise_n;
    pin_raw = 1'b1;
    cycles(6);
    pin_raw = 1'b0;
    cycles(40);
    check("R6 short pulse rejected", rise_n - r0, 0);
    check("R6 level stays low", int'(flt_level), 0);
    pin_raw = 1'b1;
    wait_rise(40, n);
    check_range("R5 filtered rise delay", n, 12, 20);
    check("R5 level high", int'(flt_level), 1);
  endtask

  task automatic t_tick_rate();
    int n;
    settle_low();
    flt_psc = 4'd7; flt_val = 4'd1;
    cycles(4);
    pin_raw = 1'b1;
    // 5 ticks of 8 cycles after the 6-cycle input path
    wait_rise(80, n);
    check_range("R4 tick every psc+1 cycles", n, 6 + 4*8, 6 + 5*8 + 2);
  endtask

  task automatic t_cfg_restart();
    int n;
    settle_low();
    flt_psc = 4'd3; flt_val = 4'd2;
    cycles(4);
    pin_raw = 1'b1;
    cycles(30);
    check("R8 no rise before change", rise_n > 0 && flt_level ? 1 : int'(flt_level), 0);
    flt_val = 4'd3;
    wait_rise(80, n);
    check_range("R8 count restarted on change", n, 46, 60);
  endtask

  task automatic t_max();
    int n, r0;
    settle_low();
    flt_psc = 4'd15; flt_val = 4'd15;
    cycles(4);
    r0 = rise_n;
    pin_raw = 1'b1;
    cycles(900);
    pin_raw = 1'b0;
    cycles(100);
    check("R9 900-cycle pulse rejected", rise_n - r0, 0);
    pin_raw = 1'b1;
    wait_rise(1100, n);
    check_range("R9 max setting rise delay", n, 950, 1000);
  endtask

  initial begin
    t_reset();
    t_bypass(4'd5, 4'd0);
    t_bypass(4'd0, 4'd5);
    t_timer_gate();
    t_filter_basic();
    t_tick_rate();
    t_cfg_restart();
    t_max();
    settle_low();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule